// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block is the counting core of a real-time clock. A strobe input arrives at 32.768 kHz, and the block counts these strobes down to one step per second. Each step advances a calendar held in BCD: seconds, minutes, hours, day of the week, day of the month, month and a two-digit year. The year, month and day-of-month fields handle leap years correctly for the range 2000 to 2099. An external calibration block can lengthen or shorten a second by one strobe at a time.

Software never reads or writes the running counters directly. It sees a separate bank of user registers through a plain address, data and strobe port. When neither control bit is set, the bank follows the running time. Setting the snapshot bit freezes a coherent copy of the time. Setting the lock bit holds the bank so that software can edit it. Clearing the lock bit loads the edited values into the running core and restarts the sub-second count.

Top module: `bcd_rtc_core`

## Requirements
- R1: The core advances by exactly one second on the TICKS_PER_SEC-th counted strobe, and `sec_pulse` is high for that one clock cycle only.
- R2: Seconds and minutes count 00 to 59, and hours count 00 to 23, all in BCD. Each wrap carries into the next field in the same step. An hour wrap advances the day of the week, which counts 1 to 7 and wraps back to 1, and advances the day of the month.
- R3: Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year is divisible by four and 28 days otherwise. All other months have 31 days. A month-end wraps the day to 01 and advances the month. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R4: Writing control with bit 0 changing from 0 to 1 copies the core time into the user registers. If the same clock completes a second, the copy already holds the advanced time.
- R5: While bit 0 is 1, the user registers do not follow the core. After bit 0 is cleared, they show the current core time.
- R6: While bit 1 is 1, the user registers hold the values they had when bit 1 was set, and software may overwrite them. Writing control with bit 1 changing from 1 to 0 loads the user registers into the core.
- R7: That load clears the sub-second count, so the next advance comes after a full TICKS_PER_SEC strobes.
- R8: When both control bits are 0, reading a time register returns the current core value.
- R9: A `cal_add` pulse counts as one extra strobe. A `cal_drop` pulse cancels one strobe in its cycle.
- R10: Address 0 is control, with bit 0 as snapshot, bit 1 as lock and all other bits reading 0. Addresses 2 to 8 hold seconds, minutes, hours, day of week, date, month and year, masked to 7, 7, 6, 3, 6, 5 and 8 bits. Other addresses read 0. After reset the registers read 00:00:00, day 1, date 01, month 01, year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe per 32.768 kHz period |
| cal_add | input | 1 | Calibration: count one extra strobe |
| cal_drop | input | 1 | Calibration: cancel one strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Register write data |
| wr_en | input | 1 | Register write strobe |
| rdata | output | 8 | Register read data for `addr` |
| sec_pulse | output | 1 | One-cycle pulse per one-second advance |

## Verification
The bench starts from random valid dates and runs a random number of seconds. The count of `sec_pulse` pulses confirms the divider ratio, and a snapshot of all seven fields confirms the calendar arithmetic. Directed starts cover the boundaries:
- last second of a century year
- 28 February in leap and common years
- the last day of a 30-day month

These separate the carry chain from the month-length table. A snapshot taken in the very cycle that completes a second shows whether the pending advance is folded into the copy. Further checks cover the following behaviour:
- Timing after a commit made mid-second confirms that the divider restarts rather than carrying its old phase.
- Reads while a control bit is held confirm that the held copy stays apart from the running core.
- Dropped and added calibration strobes show a one-strobe shift in when the next second arrives.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       cal_add,
  input  logic       cal_drop,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  output logic [7:0] rdata,
  output logic       sec_pulse
);
  localparam int DW = $clog2(TICKS_PER_SEC + 2);
  localparam logic [DW:0] TPS = (DW+1)'(TICKS_PER_SEC);

  function automatic logic [7:0] binc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic [7:0] fmask(input logic [2:0] i);
    case (i)
      3'd0, 3'd1: return 8'h7F;
      3'd2:       return 8'h3F;
      3'd3:       return 8'h07;
      3'd4:       return 8'h3F;
      3'd5:       return 8'h1F;
      default:    return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic leap;
    leap = (!yr[4] && (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8)) ||
           ( yr[4] && (yr[3:0] == 4'd2 || yr[3:0] == 4'd6));
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  logic [DW-1:0] div;
  logic [DW:0]   div_sum;
  logic [DW-1:0] div_nxt;
  logic [1:0]    step;
  logic          roll;
  logic [7:0]    core_q [7];
  logic [7:0]    core_n [7];
  logic [7:0]    user_q [7];
  logic          rs, wl;
  logic [3:0]    ofs;
  logic          ctrl_wr, rs_rise, wl_fall, time_wr, frozen;

  always_comb begin
    step = {1'b0, tick_en} + {1'b0, cal_add};
    if (cal_drop && step != 2'd0) step = step - 2'd1;
  end

  assign div_sum = {1'b0, div} + {{(DW-1){1'b0}}, step};
  assign roll    = div_sum >= TPS;
  assign div_nxt = roll ? DW'(div_sum - TPS) : div_sum[DW-1:0];

  always_comb begin
    logic cm, ch, cd, cmo, cy;
    for (int i = 0; i < 7; i++) core_n[i] = core_q[i];
    cm = 1'b0; ch = 1'b0; cd = 1'b0; cmo = 1'b0; cy = 1'b0;
    if (roll) begin
      if (core_q[0] == 8'h59) begin core_n[0] = 8'h00; cm = 1'b1; end
      else core_n[0] = binc(core_q[0]);
    end
    if (cm) begin
      if (core_q[1] == 8'h59) begin core_n[1] = 8'h00; ch = 1'b1; end
      else core_n[1] = binc(core_q[1]);
    end
    if (ch) begin
      if (core_q[2] == 8'h23) begin core_n[2] = 8'h00; cd = 1'b1; end
      else core_n[2] = binc(core_q[2]);
    end
    if (cd) begin
      core_n[3] = (core_q[3] == 8'h07) ? 8'h01 : core_q[3] + 8'd1;
      if (core_q[4] == month_len(core_q[5], core_q[6])) begin core_n[4] = 8'h01; cmo = 1'b1; end
      else core_n[4] = binc(core_q[4]);
    end
    if (cmo) begin
      if (core_q[5] == 8'h12) begin core_n[5] = 8'h01; cy = 1'b1; end
      else core_n[5] = binc(core_q[5]);
    end
    if (cy) core_n[6] = (core_q[6] == 8'h99) ? 8'h00 : binc(core_q[6]);
  end

  assign ofs     = addr - 4'd2;
  assign ctrl_wr = wr_en && addr == 4'd0;
  assign rs_rise = ctrl_wr && wdata[0] && !rs;
  assign wl_fall = ctrl_wr && !wdata[1] && wl;
  assign time_wr = wr_en && addr >= 4'd2 && addr <= 4'd8;
  assign frozen  = rs || wl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div       <= '0;
      sec_pulse <= 1'b0;
      rs        <= 1'b0;
      wl        <= 1'b0;
      for (int i = 0; i < 7; i++) begin
        core_q[i] <= (i == 3 || i == 4 || i == 5) ? 8'h01 : 8'h00;
        user_q[i] <= (i == 3 || i == 4 || i == 5) ? 8'h01 : 8'h00;
      end
    end else begin
      sec_pulse <= roll && !wl_fall;
      if (ctrl_wr) begin
        rs <= wdata[0];
        wl <= wdata[1];
      end
      if (wl_fall) begin
        div <= '0;
        for (int i = 0; i < 7; i++) core_q[i] <= user_q[i];
      end else begin
        div <= div_nxt;
        for (int i = 0; i < 7; i++) core_q[i] <= core_n[i];
      end
      if (rs_rise || !frozen) begin
        for (int i = 0; i < 7; i++) user_q[i] <= core_n[i];
      end else if (time_wr) begin
        user_q[ofs[2:0]] <= wdata & fmask(ofs[2:0]);
      end
    end
  end

  always_comb begin
    if (addr == 4'd0)                      rdata = {6'd0, wl, rs};
    else if (addr >= 4'd2 && addr <= 4'd8) rdata = user_q[ofs[2:0]] & fmask(ofs[2:0]);
    else                                   rdata = 8'h00;
  end
endmodule

module bcd_rtc_core_chk #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sec_pulse,
  input logic          rs,
  input logic          wl,
  input logic          wr_en,
  input logic [DW-1:0] div,
  input logic [7:0]    c_sec,
  input logic [7:0]    u_sec
);
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && TICKS_PER_SEC > 2) |=> !sec_pulse);
  assert_div_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(div) < TICKS_PER_SEC);
  assert_bcd_sec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_sec[3:0] <= 4'd9 && c_sec <= 8'h59);
  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rs) && rs && !$past(wr_en)) |-> $stable(u_sec));
  assert_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wl) |-> c_sec == $past(u_sec));
  assert_div_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wl) |-> (div == '0 && !sec_pulse));
  assert_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rs && !wl && !$past(rs) && !$past(wl) && !$past(wr_en)) |-> u_sec == c_sec);
endmodule

bind bcd_rtc_core bcd_rtc_core_chk #(.TICKS_PER_SEC(TICKS_PER_SEC), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .rs(rs), .wl(wl), .wr_en(wr_en),
  .div(div), .c_sec(core_q[0]), .u_sec(user_q[0])
);

// File: tb/bcd_rtc_core_bench.sv
`timescale 1ns/1ps
module bcd_rtc_core_bench;
  localparam int TPS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 1'b0, cal_add = 1'b0, cal_drop = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic sec_pulse;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_s, m_mi, m_h, m_dw, m_d, m_mo, m_y;

  always #4 clk = ~clk;

  bcd_rtc_core #(.TICKS_PER_SEC(TPS)) u_bcd_rtc_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cal_add(cal_add), .cal_drop(cal_drop),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rdata(rdata), .sec_pulse(sec_pulse));

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic madv();
    m_s++;
    if (m_s == 60) begin m_s = 0; m_mi++; end
    if (m_mi == 60) begin m_mi = 0; m_h++; end
    if (m_h == 24) begin
      m_h = 0;
      m_dw = (m_dw == 7) ? 1 : m_dw + 1;
      m_d++;
      if (m_d > dim(m_mo, m_y)) begin
        m_d = 1; m_mo++;
        if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
      end
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic run_ticks(input int n, output int pulses);
    pulses = 0;
    if (n > 0) begin
      @(negedge clk); tick_en = 1'b1;
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        if (sec_pulse) pulses++;
      end
      tick_en = 1'b0;
    end
  endtask

  task automatic set_time(input int s, input int mi, input int h, input int dw,
                          input int d, input int mo, input int y);
    wr(4'd0, 8'h02);
    wr(4'd2, bcd(s)); wr(4'd3, bcd(mi)); wr(4'd4, bcd(h)); wr(4'd5, bcd(dw));
    wr(4'd6, bcd(d)); wr(4'd7, bcd(mo)); wr(4'd8, bcd(y));
    wr(4'd0, 8'h00);
    m_s = s; m_mi = mi; m_h = h; m_dw = dw; m_d = d; m_mo = mo; m_y = y;
  endtask

  task automatic read_all(input string req);
    logic [7:0] v;
    rd(4'd2, v); chk(req, v, bcd(m_s));
    rd(4'd3, v); chk(req, v, bcd(m_mi));
    rd(4'd4, v); chk(req, v, bcd(m_h));
    rd(4'd5, v); chk(req, v, bcd(m_dw));
    rd(4'd6, v); chk(req, v, bcd(m_d));
    rd(4'd7, v); chk(req, v, bcd(m_mo));
    rd(4'd8, v); chk(req, v, bcd(m_y));
  endtask

  task automatic snap_check(input string req);
    wr(4'd0, 8'h01);
    read_all(req);
    wr(4'd0, 8'h00);
  endtask

  task automatic advance_check(input int n, input string req);
    int p;
    run_ticks(n * TPS, p);
    chk("R1", 8'(p), 8'(n));
    for (int i = 0; i < n; i++) madv();
    snap_check(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] v, old;
    int p, n, y, mo, d;
    void'($urandom(32'h1F2E3D4C));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {7'd0, sec_pulse}, 8'h00);
    rd(4'd0, v); chk("R10", v, 8'h00);
    rd(4'd1, v); chk("R10", v, 8'h00);
    m_s = 0; m_mi = 0; m_h = 0; m_dw = 1; m_d = 1; m_mo = 1; m_y = 0;
    read_all("R10");

    wr(4'd0, 8'h02);
    wr(4'd5, 8'hFF);
    rd(4'd5, v); chk("R10", v, 8'h07);
    rd(4'd0, v); chk("R10", v, 8'h02);

    set_time(59, 59, 23, 7, 31, 12, 99); advance_check(1, "R2");
    set_time(58, 59, 23, 3, 28, 2, 24);  advance_check(2, "R3");
    set_time(59, 59, 23, 3, 28, 2, 23);  advance_check(1, "R3");
    set_time(59, 59, 23, 2, 29, 2, 0);   advance_check(1, "R3");
    set_time(59, 59, 23, 4, 30, 4, 15);  advance_check(1, "R3");
    set_time(59, 59, 23, 4, 30, 5, 15);  advance_check(1, "R3");
    set_time(59, 59, 9, 5, 10, 6, 42);   advance_check(1, "R2");

    // R4: snapshot requested in the cycle a second completes
    set_time(59, 14, 8, 2, 3, 4, 5);
    run_ticks(TPS - 1, p);
    rd(4'd2, v); chk("R8", v, bcd(59));
    @(negedge clk); tick_en = 1'b1; addr = 4'd0; wdata = 8'h01; wr_en = 1'b1;
    @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
    chk("R1", {7'd0, sec_pulse}, 8'h01);
    madv();
    read_all("R4");

    // R5: frozen while snapshot bit held
    run_ticks(3 * TPS, p);
    rd(4'd2, v); chk("R5", v, bcd(m_s));
    wr(4'd0, 8'h00);
    for (int i = 0; i < 3; i++) madv();
    read_all("R5");

    // R6/R7: lock, run, edit, commit mid-second
    set_time(10, 20, 5, 1, 9, 9, 9);
    wr(4'd0, 8'h02);
    run_ticks(2 * TPS + 3, p);
    rd(4'd2, old); chk("R6", old, bcd(10));
    wr(4'd2, bcd(40));
    wr(4'd0, 8'h00);
    m_s = 40;
    run_ticks(TPS - 1, p);
    chk("R7", 8'(p), 8'd0);
    rd(4'd2, v); chk("R7", v, bcd(40));
    run_ticks(1, p);
    chk("R7", 8'(p), 8'd1);
    madv();
    read_all("R6");

    // R9: dropped strobe delays, added strobe advances the second
    set_time(0, 0, 0, 1, 1, 1, 1);
    @(negedge clk); tick_en = 1'b1; cal_drop = 1'b1;
    @(negedge clk); tick_en = 1'b0; cal_drop = 1'b0;
    run_ticks(TPS - 1, p); chk("R9", 8'(p), 8'd0);
    run_ticks(1, p);       chk("R9", 8'(p), 8'd1);
    set_time(0, 0, 0, 1, 1, 1, 1);
    @(negedge clk); cal_add = 1'b1;
    @(negedge clk); cal_add = 1'b0;
    run_ticks(TPS - 2, p); chk("R9", 8'(p), 8'd0);
    run_ticks(1, p);       chk("R9", 8'(p), 8'd1);

    for (int it = 0; it < 25; it++) begin
      y = $urandom_range(0, 99);
      mo = $urandom_range(1, 12);
      d = (it % 3 == 0) ? dim(mo, y) : $urandom_range(1, dim(mo, y));
      set_time((it % 2 == 0) ? $urandom_range(50, 59) : $urandom_range(0, 59),
               (it % 3 == 0) ? 59 : $urandom_range(0, 59),
               (it % 3 == 0) ? 23 : $urandom_range(0, 23),
               $urandom_range(1, 7), d, mo, y);
      n = $urandom_range(1, 70);
      advance_check(n, (it % 2 == 0) ? "R2" : "R3");
    end
    finish_run();
  end
endmodule